// File: doc/BRIEF.md
# Ethernet Receive Length Guard and Type-Frame CRC Remover

This block sits in the receive path of a 10/100 Ethernet MAC. It takes the byte-wide stream that comes out of preamble detection and passes a cleaned-up stream on to the application side. It does three jobs on that stream.

First, in half duplex it can throw away frames that start while the local transmitter is active, so that the MAC does not receive its own transmissions. Second, a length guard cuts off any frame that grows past a limit. The limit is a short one while the guard is armed and a long one while it is switched off. Third, it can remove the four trailing CRC bytes from frames whose length/type field holds a type code.

The output carries one byte per valid cycle and a last marker. A four-bit status word is valid together with the last marker. A four-byte delay line is all the storage the block has. After a frame is closed, up to four drain cycles follow, and during them input is not taken.

Top module: `eth_rx_guard`

## Requirements
- R1: Every accepted byte is delivered unchanged and in order. The marker `out_last` is set on the final delivered byte only. Each output byte appears in the cycle after the byte four positions later is accepted, or in a drain cycle after the frame is closed.
- R2: When `cfg_half_duplex`, `cfg_drop_own` and `tx_active` are all high in the start-of-frame cycle, no byte of that frame is delivered. The rest of the frame is ignored up to its end marker.
- R3: When `cfg_drop_own` is low, frames are delivered whatever the level of `tx_active`.
- R4: When `cfg_half_duplex` is low, `cfg_drop_own` has no effect and frames are delivered while `tx_active` is high.
- R5: With `cfg_wdog_off` low, a frame longer than SHORT_LIMIT bytes is cut to its first SHORT_LIMIT bytes. `out_last` is set on byte SHORT_LIMIT, status bit 0 (timeout) is set, and the bytes beyond the limit are dropped.
- R6: With `cfg_wdog_off` high, frames of up to LONG_LIMIT bytes pass whole. Longer frames are cut at LONG_LIMIT in the same way as in R5.
- R7: A frame of 14 or more kept bytes is a type frame when bytes 12 (high) and 13 (low), counted from 0, form a value of 0x0600 or more. Status bit 2 reports this on the last byte.
- R8: With `cfg_strip_type` high, a type frame that was not cut loses its last four bytes. `out_last` sits on byte N-4, and status bit 3 (stripped) is set.
- R9: Frames that are not type frames, frames while `cfg_strip_type` is low, and frames that were cut are delivered without removing any byte, and status bit 3 stays clear.
- R10: A frame of fewer than four bytes is delivered whole, and status bit 1 (runt) is set.
- R11: `out_status` is zero on every output cycle that does not carry `out_last`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Input byte present |
| in_data | input | 8 | Input byte |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Final byte of a frame |
| cfg_half_duplex | input | 1 | MAC runs in half duplex |
| cfg_drop_own | input | 1 | Drop frames received while transmitting (half duplex only) |
| cfg_wdog_off | input | 1 | Use the long length limit instead of the short one |
| cfg_strip_type | input | 1 | Remove the CRC from type frames |
| tx_active | input | 1 | Local transmit enable |
| out_valid | output | 1 | Output byte present |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final byte of the delivered frame |
| out_status | output | 4 | Bit 0 timeout, bit 1 runt, bit 2 type frame, bit 3 stripped; valid with out_last |

## Verification
A wrong fill level in the delay line shows up at the next frame end. The last marker then lands too early or too late, or a stale byte comes out, and the byte-by-byte frame comparison catches this within a few cycles. A byte counter that is off by one moves the cut point or the type-field capture. This is seen as a wrong length or a wrong type/stripped bit on the last byte. The bench aims sweeps at frame lengths on either side of both limits and at the values 0x05FF and 0x0600 to find such errors. A decision state that gets stuck shows as missing output on the frame after a dropped or cut one, and the bench checks that frame too.

// File: rtl/eth_rx_guard_pkg.sv
package eth_rx_guard_pkg;
  typedef enum logic [1:0] {
    GS_IDLE  = 2'd0,
    GS_RECV  = 2'd1,
    GS_DRAIN = 2'd2,
    GS_SKIP  = 2'd3
  } guard_state_e;

  localparam int STW        = 4;
  localparam int SB_TIMEOUT = 0;
  localparam int SB_RUNT    = 1;
  localparam int SB_TYPE    = 2;
  localparam int SB_STRIP   = 3;

  localparam int          TYPE_HI_POS = 12;
  localparam int          TYPE_LO_POS = 13;
  localparam logic [15:0] TYPE_FLOOR  = 16'h0600;
endpackage

// File: rtl/rxg_delay_line.sv
module rxg_delay_line #(
  parameter int W = 8,
  parameter int D = 4,
  localparam int AW = $clog2(D),
  localparam int LW = $clog2(D + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic          clear,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  dout,
  output logic          full,
  output logic [LW-1:0] level
);
  logic [W-1:0]  stage_q [D];
  logic [LW-1:0] level_q, level_d;
  logic [LW-1:0] oldest;

  assign full   = (level_q == LW'(D));
  assign level  = level_q;
  assign oldest = level_q - LW'(1);
  assign dout   = stage_q[oldest[AW-1:0]];

  always_comb begin
    level_d = level_q;
    if (clear)
      level_d = '0;
    else if (push && !full)
      level_d = level_q + LW'(1);
    else if (pop)
      level_d = level_q - LW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      level_q <= '0;
    else
      level_q <= level_d;
  end

  always_ff @(posedge clk) begin
    if (push) begin
      stage_q[0] <= din;
      for (int i = 1; i < D; i++)
        stage_q[i] <= stage_q[i-1];
    end
  end

  // R1: the control only drains a non-empty line and never mixes fill and drain
  a_r1_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (level_q != '0) && !push);
  a_r1_level_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    level_q <= LW'(D));
endmodule

// File: rtl/rxg_type_detect.sv
module rxg_type_detect
  import eth_rx_guard_pkg::*;
#(
  parameter int CW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic [CW-1:0] idx,
  input  logic [7:0]    din,
  output logic          is_type
);
  logic [7:0] hi_q, hi_d;
  logic       flag_q, flag_d;
  logic       at_lo;
  logic       cmp_now;

  assign at_lo   = (idx == CW'(TYPE_LO_POS));
  assign cmp_now = ({hi_q, din} >= TYPE_FLOOR);
  assign is_type = at_lo ? cmp_now : ((idx > CW'(TYPE_LO_POS)) && flag_q);

  always_comb begin
    hi_d   = hi_q;
    flag_d = flag_q;
    if (take && idx == CW'(TYPE_HI_POS))
      hi_d = din;
    if (take && at_lo)
      flag_d = cmp_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= '0;
      flag_q <= 1'b0;
    end else begin
      hi_q   <= hi_d;
      flag_q <= flag_d;
    end
  end

  // R7: the type flag can only be raised once the low field byte has been seen
  a_r7_flag_after_field: assert property (@(posedge clk) disable iff (!rst_n)
    (take && idx < CW'(TYPE_LO_POS)) |-> !is_type);
endmodule

// File: rtl/eth_rx_guard.sv
module eth_rx_guard
  import eth_rx_guard_pkg::*;
#(
  parameter int SHORT_LIMIT = 2048,
  parameter int LONG_LIMIT  = 16384,
  parameter int CRC_BYTES   = 4,
  localparam int CW = $clog2(LONG_LIMIT + 2),
  localparam int LW = $clog2(CRC_BYTES + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [7:0]     in_data,
  input  logic           in_sof,
  input  logic           in_eof,
  input  logic           cfg_half_duplex,
  input  logic           cfg_drop_own,
  input  logic           cfg_wdog_off,
  input  logic           cfg_strip_type,
  input  logic           tx_active,
  output logic           out_valid,
  output logic [7:0]     out_data,
  output logic           out_last,
  output logic [STW-1:0] out_status
);
  guard_state_e   state_q, state_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic           done_q, done_d;
  logic [STW-1:0] st_q, st_d;

  logic           ov_q, ov_d;
  logic [7:0]     od_q, od_d;
  logic           ol_q, ol_d;
  logic [STW-1:0] os_q, os_d;

  logic           dl_push, dl_pop, dl_clear, dl_full;
  logic [7:0]     dl_dout;
  logic [LW-1:0]  dl_level;

  logic [CW-1:0]  limit;
  logic           start, own_drop, take, over;
  logic [CW-1:0]  idx, nbytes;
  logic           type_now, strip_now, end_seen;

  assign limit     = cfg_wdog_off ? CW'(LONG_LIMIT) : CW'(SHORT_LIMIT);
  assign start     = in_valid && in_sof && (state_q == GS_IDLE);
  assign own_drop  = cfg_half_duplex && cfg_drop_own && tx_active;
  assign take      = (start && !own_drop) || (in_valid && state_q == GS_RECV);
  assign idx       = (state_q == GS_IDLE) ? '0 : cnt_q;
  assign nbytes    = idx + CW'(1);
  assign over      = take && (nbytes > limit);
  assign strip_now = cfg_strip_type && type_now;
  assign end_seen  = in_valid && in_eof;

  rxg_delay_line #(.W(8), .D(CRC_BYTES)) u_line (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (dl_push),
    .pop   (dl_pop),
    .clear (dl_clear),
    .din   (in_data),
    .dout  (dl_dout),
    .full  (dl_full),
    .level (dl_level)
  );

  rxg_type_detect #(.CW(CW)) u_type (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (take),
    .idx     (idx),
    .din     (in_data),
    .is_type (type_now)
  );

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    done_d   = done_q;
    st_d     = st_q;
    dl_push  = 1'b0;
    dl_pop   = 1'b0;
    dl_clear = 1'b0;
    ov_d     = 1'b0;
    od_d     = dl_dout;
    ol_d     = 1'b0;
    os_d     = '0;

    unique case (state_q)
      GS_IDLE: begin
        if (start && own_drop && !in_eof)
          state_d = GS_SKIP;
      end
      GS_DRAIN: begin
        dl_pop = 1'b0;
        if (dl_level != '0) begin
          dl_pop = 1'b1;
          ov_d   = 1'b1;
        end
        if (end_seen)
          done_d = 1'b1;
        if (dl_level == LW'(1)) begin
          ol_d    = 1'b1;
          os_d    = st_q;
          state_d = (done_q || end_seen) ? GS_IDLE : GS_SKIP;
        end
      end
      GS_SKIP: begin
        if (end_seen)
          state_d = GS_IDLE;
      end
      default: ;
    endcase

    if (take) begin
      cnt_d   = nbytes;
      state_d = GS_RECV;
      if (over) begin
        st_d              = '0;
        st_d[SB_TIMEOUT]  = 1'b1;
        st_d[SB_TYPE]     = type_now;
        done_d            = in_eof;
        state_d           = GS_DRAIN;
      end else begin
        dl_push = 1'b1;
        ov_d    = dl_full;
        if (in_eof) begin
          if (strip_now) begin
            ol_d           = 1'b1;
            os_d[SB_TYPE]  = 1'b1;
            os_d[SB_STRIP] = 1'b1;
            dl_clear       = 1'b1;
            state_d        = GS_IDLE;
          end else begin
            st_d          = '0;
            st_d[SB_TYPE] = type_now;
            st_d[SB_RUNT] = (nbytes < CW'(CRC_BYTES));
            done_d        = 1'b1;
            state_d       = GS_DRAIN;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= GS_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      st_q    <= '0;
      ov_q    <= 1'b0;
      ol_q    <= 1'b0;
      os_q    <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
      st_q    <= st_d;
      ov_q    <= ov_d;
      ol_q    <= ol_d;
      os_q    <= os_d;
    end
  end

  always_ff @(posedge clk) begin
    if (ov_d)
      od_q <= od_d;
  end

  assign out_valid  = ov_q;
  assign out_data   = od_q;
  assign out_last   = ol_q;
  assign out_status = os_q;

  // Output-side byte position, used by the checks below
  logic [CW-1:0] ocnt_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ocnt_q <= '0;
    else if (ov_q)
      ocnt_q <= ol_q ? '0 : ocnt_q + CW'(1);
  end

  // R11: status only accompanies the last byte
  a_r11_status_on_last: assert property (@(posedge clk) disable iff (!rst_n)
    (os_q != '0) |-> (ov_q && ol_q));
  // R1: a last marker never appears without a byte
  a_r1_last_has_byte: assert property (@(posedge clk) disable iff (!rst_n)
    ol_q |-> ov_q);
  // R2: a frame being skipped produces nothing after the first skip cycle
  a_r2_skip_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == GS_SKIP && $past(state_q) == GS_SKIP) |-> !ov_q);
  // R5: a cut frame closes exactly at the active limit
  a_r5_cut_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (ov_q && ol_q && os_q[SB_TIMEOUT]) |-> (ocnt_q == limit - CW'(1)));
  // R6: no delivered frame grows past the long limit
  a_r6_long_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    ov_q |-> (ocnt_q < CW'(LONG_LIMIT)));
  // R8: only uncut type frames are stripped
  a_r8_strip_type_only: assert property (@(posedge clk) disable iff (!rst_n)
    (ol_q && os_q[SB_STRIP]) |-> (os_q[SB_TYPE] && !os_q[SB_TIMEOUT]));
  // R10: runt frames are short and never cut
  a_r10_runt_short: assert property (@(posedge clk) disable iff (!rst_n)
    (ol_q && os_q[SB_RUNT]) |-> (ocnt_q < CW'(CRC_BYTES - 1) && !os_q[SB_TIMEOUT]));
endmodule

// File: tb/sim_eth_rx_guard.sv
`timescale 1ns/1ps
module sim_eth_rx_guard;
  localparam int SHORT_L = 24;
  localparam int LONG_L  = 40;

  logic       clk;
  logic       rst_n;
  logic       in_valid, in_sof, in_eof;
  logic [7:0] in_data;
  logic       cfg_half_duplex, cfg_drop_own, cfg_wdog_off, cfg_strip_type, tx_active;
  logic       out_valid, out_last;
  logic [7:0] out_data;
  logic [3:0] out_status;

  int checks = 0;
  int fails  = 0;

  eth_rx_guard #(.SHORT_LIMIT(SHORT_L), .LONG_LIMIT(LONG_L), .CRC_BYTES(4)) u0 (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
    .cfg_half_duplex(cfg_half_duplex), .cfg_drop_own(cfg_drop_own),
    .cfg_wdog_off(cfg_wdog_off), .cfg_strip_type(cfg_strip_type),
    .tx_active(tx_active),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
    .out_status(out_status)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Output capture
  logic [7:0] ob_d [64];
  int  ob_n;
  int  lasts;
  int  last_pos;
  logic [3:0] last_st;

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (ob_n < 64) ob_d[ob_n] = out_data;
      if (out_last) begin
        lasts++;
        last_pos = ob_n;
        last_st  = out_status;
      end else begin
        chk(out_status == 4'd0, "R11 status off last", int'(out_status), 0);
      end
      ob_n++;
    end
  end

  function automatic logic [7:0] gen_byte(input int i, input int len, input logic [15:0] fld);
    if (i == 12) return fld[15:8];
    if (i == 13) return fld[7:0];
    if (i < 12)  return 8'((i * 37 + len) & 255);
    return 8'((i * 11 + 3 + len) & 255);
  endfunction

  task automatic run_frame(input int len, input logic [15:0] fld, input bit dropped,
                           input string tag);
    int lim, kept, exp_n, mism;
    bit trunc, typ, strp, runt;
    logic [3:0] exp_st;
    ob_n = 0; lasts = 0; last_pos = -1; last_st = 4'd0;
    for (int i = 0; i < len; i++) begin
      if (i % 5 == 3) begin
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
      end
      @(negedge clk);
      in_valid = 1'b1;
      in_sof   = (i == 0);
      in_eof   = (i == len - 1);
      in_data  = gen_byte(i, len, fld);
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    repeat (10) @(negedge clk);

    lim   = cfg_wdog_off ? LONG_L : SHORT_L;
    trunc = (len > lim);
    kept  = trunc ? lim : len;
    typ   = (kept >= 14) && (fld >= 16'h0600);
    strp  = !trunc && cfg_strip_type && typ;
    runt  = !trunc && (len < 4);
    exp_n = dropped ? 0 : (strp ? len - 4 : kept);
    exp_st = {strp, typ, runt, trunc};

    chk(ob_n == exp_n, {tag, " byte count"}, ob_n, exp_n);
    if (exp_n == 0) begin
      chk(lasts == 0, {tag, " no last"}, lasts, 0);
    end else begin
      chk(lasts == 1 && last_pos == exp_n - 1, {tag, " last position"}, last_pos, exp_n - 1);
      mism = 0;
      for (int k = 0; k < exp_n && k < 64; k++)
        if (ob_d[k] !== gen_byte(k, len, fld)) mism++;
      chk(mism == 0, {tag, " byte content"}, mism, 0);
      chk(last_st == exp_st, (kept >= 14) ? {tag, " R7 status"} : {tag, " status"},
          int'(last_st), int'(exp_st));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL R1 watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int lens [17] = '{1, 2, 3, 4, 5, 13, 14, 15, 18, 23, 24, 25, 30, 39, 40, 41, 47};
    logic [15:0] flds [4] = '{16'h002E, 16'h05FF, 16'h0600, 16'h86DD};
    string tag;
    rst_n = 1'b0;
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_data = 8'd0;
    cfg_half_duplex = 1'b0; cfg_drop_own = 1'b0; cfg_wdog_off = 1'b0;
    cfg_strip_type = 1'b0; tx_active = 1'b0;
    repeat (4) @(negedge clk);
    chk(out_valid == 1'b0 && out_last == 1'b0 && out_status == 4'd0,
        "R1 reset state", int'(out_valid), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1 idle after reset", int'(out_valid), 0);

    // Sweep: limit mode x stripping x length x length/type field
    for (int wd = 0; wd < 2; wd++) begin
      for (int st = 0; st < 2; st++) begin
        for (int li = 0; li < 17; li++) begin
          for (int fi = 0; fi < 4; fi++) begin
            int lim = (wd != 0) ? LONG_L : SHORT_L;
            bit typ = (lens[li] >= 14) && (flds[fi] >= 16'h0600);
            cfg_wdog_off   = wd[0];
            cfg_strip_type = st[0];
            if (lens[li] > lim)              tag = (wd != 0) ? "R6 long cut" : "R5 short cut";
            else if (st != 0 && typ)         tag = "R8 stripped";
            else if (lens[li] < 4)           tag = "R10 runt";
            else if (lens[li] >= 14)         tag = "R9 kept whole";
            else if (wd != 0)                tag = "R6 long pass";
            else                             tag = "R1 pass";
            run_frame(lens[li], flds[fi], 1'b0, tag);
          end
        end
      end
    end

    // Receive-own suppression
    cfg_wdog_off = 1'b0; cfg_strip_type = 1'b1;
    cfg_half_duplex = 1'b1; cfg_drop_own = 1'b1; tx_active = 1'b1;
    run_frame(30, 16'h0800, 1'b1, "R2 own frame dropped");
    run_frame(1,  16'h0800, 1'b1, "R2 one-byte own frame dropped");
    run_frame(35, 16'h0800, 1'b1, "R2 long own frame dropped");
    tx_active = 1'b0;
    run_frame(20, 16'h0800, 1'b0, "R2 recovery after drop");
    tx_active = 1'b1; cfg_drop_own = 1'b0;
    run_frame(20, 16'h0800, 1'b0, "R3 drop-own clear");
    run_frame(3,  16'h0800, 1'b0, "R3 drop-own clear runt");
    cfg_half_duplex = 1'b0; cfg_drop_own = 1'b1;
    run_frame(20, 16'h0800, 1'b0, "R4 full duplex ignores drop-own");
    run_frame(26, 16'h0040, 1'b0, "R4 full duplex cut frame");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule